// File: doc/BRIEF.md
# Programmable Logic Output Cell

This block is one output cell of a small programmable logic device. It takes the product-term results that the AND array computes for this cell and drives one bidirectional pin, modelled as a data value plus an enable. It also returns one feedback signal into the array. Two bits shared by all cells choose a mode: registered, complex or simple. The mode sets how the product terms are shared out, where the output enable comes from, and what the cell feeds back. Two more bits, private to each cell, choose the output polarity and the cell's role within the mode.

Each cell has an optional D register. It is cleared at power-up and can be forced to either value through a synchronous test preload. A parameter gives the cell's position in the device: an ordinary cell, one of the two outermost cells, or one of the two centre cells. The outermost cells carry the dedicated inputs in complex mode. The centre cells have no feedback in simple mode.

Top module: `pld_out_cell`

## Requirements
- R1: The mode comes from `glb_nreg_i` and `glb_sel_i` as follows. `glb_nreg_i`=0 selects registered mode, whatever the value of `glb_sel_i`. `glb_nreg_i`=1 with `glb_sel_i`=1 selects complex mode. `glb_nreg_i`=1 with `glb_sel_i`=0 selects simple mode.
- R2: For every combinational output, `pad_do_o` equals the OR sum when `cell_pol_i`=1 and its inverse when `cell_pol_i`=0.
- R3: In registered mode with `cell_cfg_i`=0, the register is used. A rising clock loads it with the inverse of the eight-term sum when `cell_pol_i`=1, or with the sum itself when `cell_pol_i`=0. `pad_do_o` is the inverse of the register, `pad_oe_o` follows `grp_oe_i`, and `fb_o` is the register value.
- R4: In registered mode with `cell_cfg_i`=1, and in complex mode, the sum covers terms 7..1 and `pad_oe_o` equals term 0. `fb_o` equals `pin_in_i`, except as stated in R5.
- R5: For an outermost cell in complex mode, `fb_o` equals `ded_in_i`.
- R6: In simple mode with `cell_cfg_i`=0, `pad_oe_o` is 1, the sum covers all eight terms, and `fb_o` equals `adj_pin_i`.
- R7: For a cell that is not a centre cell, simple mode with `cell_cfg_i`=1 makes it a dedicated input: `pad_oe_o`=0 and `fb_o` equals `adj_pin_i`.
- R8: In simple mode a centre cell is always an enabled output, whatever the value of `cell_cfg_i`, and its `fb_o` is 0.
- R9: While `rst_ni` is low the register is 0. A registered output then drives `pad_do_o`=1 under either polarity.
- R10: `preload_en_i` high at a rising clock loads `preload_val_i` into the register. This takes priority over the normal load.
- R11: With no preload and outside the configuration of R3, the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared register clock |
| rst_ni | input | 1 | Power-up reset, active low, asynchronous |
| glb_nreg_i | input | 1 | Global mode bit: 0 selects registered mode |
| glb_sel_i | input | 1 | Global mode bit: complex (1) or simple (0) |
| cell_cfg_i | input | 1 | Per-cell role bit |
| cell_pol_i | input | 1 | Per-cell polarity: 1 active high, 0 active low |
| term_i | input | NUM_TERMS | Product-term results, a disabled term reads 0 |
| grp_oe_i | input | 1 | Shared output enable for registered outputs |
| pin_in_i | input | 1 | Level currently seen on this cell's pin |
| adj_pin_i | input | 1 | Level seen on the neighbouring pin |
| ded_in_i | input | 1 | Dedicated input routed through an outermost cell |
| preload_en_i | input | 1 | Synchronous register preload strobe |
| preload_val_i | input | 1 | Value to preload |
| pad_do_o | output | 1 | Pin data value |
| pad_oe_o | output | 1 | Pin drive enable |
| fb_o | output | 1 | Feedback into the AND array |

## Verification
On every cycle, the assertions check the enable source and feedback routing of each mode and cell position. They also check the polarity of the complex-mode output, that the register is zero under reset, that it takes the preload value, and that it holds when it is not in use. The bench's scenarios are needed to show what the register captures on a normal clock edge and what the inverted pin shows afterwards. They also show that preload wins over a conflicting sum, that a value held through other modes reappears when registered mode returns, and that the pin reads high during reset under both polarities.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;
  typedef enum logic [1:0] {MODE_REG = 2'd0, MODE_CPLX = 2'd1, MODE_SIMPLE = 2'd2} mode_e;
  typedef enum logic [1:0] {KIND_INNER = 2'd0, KIND_EDGE = 2'd1, KIND_CENTRE = 2'd2} cell_kind_e;

  function automatic mode_e decode_mode(logic nreg, logic sel);
    if (!nreg) return MODE_REG;
    else if (sel) return MODE_CPLX;
    else return MODE_SIMPLE;
  endfunction
endpackage

// File: rtl/pld_term_sum.sv
module pld_term_sum #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] term_i,
  output logic             sum_o
);
  logic [WIDTH:0] chain;
  assign chain[0] = 1'b0;
  for (genvar g = 0; g < WIDTH; g++) begin : g_or
    assign chain[g+1] = chain[g] | term_i[g];
  end
  assign sum_o = chain[WIDTH];
endmodule

// File: rtl/pld_cell_reg.sv
module pld_cell_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic d_i,
  input  logic preload_en_i,
  input  logic preload_val_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           q_o <= 1'b0;
    else if (preload_en_i) q_o <= preload_val_i;
    else if (load_i)       q_o <= d_i;
  end
endmodule

// File: rtl/pld_cell_route.sv
module pld_cell_route
  import pld_cell_pkg::*;
#(
  parameter cell_kind_e CELL_KIND = KIND_INNER
) (
  input  logic glb_nreg_i,
  input  logic glb_sel_i,
  input  logic cell_cfg_i,
  input  logic cell_pol_i,
  input  logic oe_term_i,
  input  logic sum_all_i,
  input  logic sum_io_i,
  input  logic grp_oe_i,
  input  logic q_i,
  input  logic pin_in_i,
  input  logic adj_pin_i,
  input  logic ded_in_i,
  output logic reg_load_o,
  output logic reg_d_o,
  output logic pad_do_o,
  output logic pad_oe_o,
  output logic fb_o
);
  mode_e mode;
  assign mode = decode_mode(glb_nreg_i, glb_sel_i);

  // pin shows inverted Q, so D carries the inverted polarity
  assign reg_d_o = cell_pol_i ? ~sum_all_i : sum_all_i;

  always_comb begin
    reg_load_o = 1'b0;
    pad_do_o   = cell_pol_i ? sum_io_i : ~sum_io_i;
    pad_oe_o   = 1'b0;
    fb_o       = 1'b0;
    unique case (mode)
      MODE_REG: begin
        if (!cell_cfg_i) begin
          reg_load_o = 1'b1;
          pad_do_o   = ~q_i;
          pad_oe_o   = grp_oe_i;
          fb_o       = q_i;
        end else begin
          pad_oe_o = oe_term_i;
          fb_o     = pin_in_i;
        end
      end
      MODE_CPLX: begin
        pad_oe_o = oe_term_i;
        fb_o     = (CELL_KIND == KIND_EDGE) ? ded_in_i : pin_in_i;
      end
      MODE_SIMPLE: begin
        pad_do_o = cell_pol_i ? sum_all_i : ~sum_all_i;
        pad_oe_o = (CELL_KIND == KIND_CENTRE) ? 1'b1 : ~cell_cfg_i;
        fb_o     = (CELL_KIND == KIND_CENTRE) ? 1'b0 : adj_pin_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
  import pld_cell_pkg::*;
#(
  parameter int         NUM_TERMS = 8,
  parameter cell_kind_e CELL_KIND = KIND_INNER
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 glb_nreg_i,
  input  logic                 glb_sel_i,
  input  logic                 cell_cfg_i,
  input  logic                 cell_pol_i,
  input  logic [NUM_TERMS-1:0] term_i,
  input  logic                 grp_oe_i,
  input  logic                 pin_in_i,
  input  logic                 adj_pin_i,
  input  logic                 ded_in_i,
  input  logic                 preload_en_i,
  input  logic                 preload_val_i,
  output logic                 pad_do_o,
  output logic                 pad_oe_o,
  output logic                 fb_o
);
  localparam int IO_TERMS = NUM_TERMS - 1;

  logic sum_all, sum_io, reg_load, reg_d, reg_q;

  pld_term_sum #(.WIDTH(NUM_TERMS)) u_sum_all (.term_i(term_i), .sum_o(sum_all));
  pld_term_sum #(.WIDTH(IO_TERMS))  u_sum_io  (.term_i(term_i[NUM_TERMS-1:1]), .sum_o(sum_io));

  pld_cell_reg u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(reg_load), .d_i(reg_d),
    .preload_en_i(preload_en_i), .preload_val_i(preload_val_i), .q_o(reg_q)
  );

  pld_cell_route #(.CELL_KIND(CELL_KIND)) u_route (
    .glb_nreg_i(glb_nreg_i), .glb_sel_i(glb_sel_i), .cell_cfg_i(cell_cfg_i),
    .cell_pol_i(cell_pol_i), .oe_term_i(term_i[0]), .sum_all_i(sum_all),
    .sum_io_i(sum_io), .grp_oe_i(grp_oe_i), .q_i(reg_q), .pin_in_i(pin_in_i),
    .adj_pin_i(adj_pin_i), .ded_in_i(ded_in_i), .reg_load_o(reg_load),
    .reg_d_o(reg_d), .pad_do_o(pad_do_o), .pad_oe_o(pad_oe_o), .fb_o(fb_o)
  );
endmodule

// File: rtl/pld_out_cell_chk.sv
module pld_out_cell_chk
  import pld_cell_pkg::*;
#(
  parameter int         NUM_TERMS = 8,
  parameter cell_kind_e CELL_KIND = KIND_INNER
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 glb_nreg_i,
  input logic                 glb_sel_i,
  input logic                 cell_cfg_i,
  input logic                 cell_pol_i,
  input logic [NUM_TERMS-1:0] term_i,
  input logic                 grp_oe_i,
  input logic                 pin_in_i,
  input logic                 adj_pin_i,
  input logic                 ded_in_i,
  input logic                 preload_en_i,
  input logic                 preload_val_i,
  input logic                 pad_do_o,
  input logic                 pad_oe_o,
  input logic                 fb_o,
  input logic                 reg_q
);
  logic reg_out, cplx, simple;
  assign reg_out = !glb_nreg_i && !cell_cfg_i;
  assign cplx    = glb_nreg_i && glb_sel_i;
  assign simple  = glb_nreg_i && !glb_sel_i;

  assert_reg_out_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_out |-> (pad_oe_o == grp_oe_i && fb_o == ~pad_do_o));

  assert_term_oe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!glb_nreg_i && cell_cfg_i) || cplx) |-> pad_oe_o == term_i[0]);

  assert_cplx_pol_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cplx |-> pad_do_o == ~(cell_pol_i ^ (|term_i[NUM_TERMS-1:1])));

  assert_simple_out_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (simple && !cell_cfg_i) |-> pad_oe_o);

  if (CELL_KIND == KIND_CENTRE) begin : g_centre
    assert_centre_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      simple |-> (pad_oe_o && !fb_o));
  end else begin : g_side
    assert_adj_fb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      simple |-> (fb_o == adj_pin_i && (pad_oe_o == !cell_cfg_i)));
  end

  if (CELL_KIND == KIND_EDGE) begin : g_edge
    assert_edge_fb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cplx |-> fb_o == ded_in_i);
  end

  assert_reset_clear_R9: assert property (@(posedge clk_i)
    !rst_ni |-> reg_q == 1'b0);

  assert_preload_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preload_en_i |=> reg_q == $past(preload_val_i));

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!preload_en_i && !reg_out) |=> $stable(reg_q));
endmodule

bind pld_out_cell pld_out_cell_chk #(.NUM_TERMS(NUM_TERMS), .CELL_KIND(CELL_KIND)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .glb_nreg_i(glb_nreg_i), .glb_sel_i(glb_sel_i),
  .cell_cfg_i(cell_cfg_i), .cell_pol_i(cell_pol_i), .term_i(term_i),
  .grp_oe_i(grp_oe_i), .pin_in_i(pin_in_i), .adj_pin_i(adj_pin_i),
  .ded_in_i(ded_in_i), .preload_en_i(preload_en_i), .preload_val_i(preload_val_i),
  .pad_do_o(pad_do_o), .pad_oe_o(pad_oe_o), .fb_o(fb_o), .reg_q(reg_q)
);

// File: tb/pld_out_cell_test.sv
module pld_out_cell_test;
  import pld_cell_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;

  logic clk = 1'b0;
  logic rst_ni;
  logic nreg, sel, cfg, pol, goe, pin, adj, ded, pl_en, pl_val;
  logic [NT-1:0] terms;
  logic [2:0] do_v, oe_v, fb_v;
  logic q_m;
  int total = 0;
  int bad = 0;
  bit done = 0;
  string hint = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  pld_out_cell #(.NUM_TERMS(NT), .CELL_KIND(KIND_INNER)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .glb_nreg_i(nreg), .glb_sel_i(sel), .cell_cfg_i(cfg),
    .cell_pol_i(pol), .term_i(terms), .grp_oe_i(goe), .pin_in_i(pin), .adj_pin_i(adj),
    .ded_in_i(ded), .preload_en_i(pl_en), .preload_val_i(pl_val),
    .pad_do_o(do_v[0]), .pad_oe_o(oe_v[0]), .fb_o(fb_v[0]));
  pld_out_cell #(.NUM_TERMS(NT), .CELL_KIND(KIND_EDGE)) uut_edge (
    .clk_i(clk), .rst_ni(rst_ni), .glb_nreg_i(nreg), .glb_sel_i(sel), .cell_cfg_i(cfg),
    .cell_pol_i(pol), .term_i(terms), .grp_oe_i(goe), .pin_in_i(pin), .adj_pin_i(adj),
    .ded_in_i(ded), .preload_en_i(pl_en), .preload_val_i(pl_val),
    .pad_do_o(do_v[1]), .pad_oe_o(oe_v[1]), .fb_o(fb_v[1]));
  pld_out_cell #(.NUM_TERMS(NT), .CELL_KIND(KIND_CENTRE)) uut_ctr (
    .clk_i(clk), .rst_ni(rst_ni), .glb_nreg_i(nreg), .glb_sel_i(sel), .cell_cfg_i(cfg),
    .cell_pol_i(pol), .term_i(terms), .grp_oe_i(goe), .pin_in_i(pin), .adj_pin_i(adj),
    .ded_in_i(ded), .preload_en_i(pl_en), .preload_val_i(pl_val),
    .pad_do_o(do_v[2]), .pad_oe_o(oe_v[2]), .fb_o(fb_v[2]));

  // expected {do, oe, fb} for cell kind k (0 inner, 1 edge, 2 centre)
  function automatic logic [2:0] expect_out(int k);
    logic s_all, s_io;
    s_all = |terms;
    s_io  = |terms[NT-1:1];
    if (!nreg) begin
      if (!cfg) return {~q_m, goe, q_m};
      return {pol ? s_io : ~s_io, terms[0], pin};
    end
    if (sel) return {pol ? s_io : ~s_io, terms[0], (k == 1) ? ded : pin};
    return {pol ? s_all : ~s_all, (k == 2) ? 1'b1 : ~cfg, (k == 2) ? 1'b0 : adj};
  endfunction

  function automatic logic next_q();
    if (pl_en) return pl_val;
    if (!nreg && !cfg) return pol ? ~(|terms) : (|terms);
    return q_m;
  endfunction

  function automatic string tag_of(int k);
    if (hint != "") return hint;
    if (!nreg) return cfg ? "R4" : "R3";
    if (sel) return (k == 1) ? "R5" : "R4";
    if (k == 2) return "R8";
    return cfg ? "R7" : "R6";
  endfunction

  task automatic check_all();
    for (int k = 0; k < 3; k++) begin
      logic [2:0] got, exp;
      got = {do_v[k], oe_v[k], fb_v[k]};
      exp = expect_out(k);
      total++;
      if (got !== exp) begin
        bad++;
        $display("FAIL %s cell%0d {do,oe,fb} got=%b exp=%b", tag_of(k), k, got, exp);
      end
    end
  endtask

  // inputs already driven after a falling edge
  task automatic cycle();
    logic nq;
    #2;
    check_all();
    nq = next_q();
    @(posedge clk);
    q_m = nq;
    @(negedge clk);
  endtask

  task automatic set_cfg(logic n, logic s, logic c, logic p);
    nreg = n; sel = s; cfg = c; pol = p;
  endtask

  initial begin
    rst_ni = 1'b1; q_m = 1'b0;
    set_cfg(0, 1, 0, 0);
    terms = '0; goe = 1; pin = 0; adj = 0; ded = 0; pl_en = 0; pl_val = 0;
    #2 rst_ni = 1'b0;
    // R9: pin of an enabled registered output reads high under both polarities
    for (int p = 0; p < 2; p++) begin
      pol = p[0]; terms = 8'hFF;
      @(negedge clk); #1;
      total++;
      if (do_v[0] !== 1'b1 || oe_v[0] !== 1'b1) begin
        bad++; $display("FAIL R9 pol=%0d do=%b oe=%b exp do=1 oe=1", p, do_v[0], oe_v[0]);
      end
    end
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);

    // R1: both global bits low decodes as registered; R3 load of inverse sum
    hint = "R1"; set_cfg(0, 0, 0, 1); terms = 8'h10; cycle();
    hint = "R3"; terms = 8'h00; cycle(); cycle();
    // R10: preload wins over conflicting sum
    hint = "R10"; pol = 1; terms = 8'hFF; pl_en = 1; pl_val = 1; cycle();
    pl_en = 1; pl_val = 0; terms = 8'h00; cycle();
    pl_en = 0; cycle();
    // R11: hold through complex and simple modes, reappears in registered mode
    hint = "R11"; pl_en = 1; pl_val = 1; cycle(); pl_en = 0;
    set_cfg(1, 1, 1, 0); terms = 8'h00; cycle();
    set_cfg(1, 0, 1, 1); terms = 8'h00; cycle();
    set_cfg(0, 1, 1, 1); cycle();
    set_cfg(0, 1, 0, 1); terms = 8'h00; cycle();
    // R2: polarity flip in complex mode, oe term not in the sum
    hint = "R2"; set_cfg(1, 1, 1, 1); terms = 8'h01; cycle();
    pol = 0; cycle(); terms = 8'h80; cycle(); pol = 1; cycle();
    // R5, R8 directed
    hint = "R5"; ded = 1; pin = 0; cycle(); ded = 0; pin = 1; cycle();
    hint = "R8"; set_cfg(1, 0, 1, 0); adj = 1; terms = 8'h00; cycle();
    hint = "";

    void'($urandom(32'h5A17));
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom();
      nreg = r[0]; sel = r[1]; cfg = r[2]; pol = r[3]; goe = r[4];
      pin = r[5]; adj = r[6]; ded = r[7];
      pl_en = (r[10:8] == 3'd0); pl_val = r[11];
      terms = (r[14:12] == 3'd0) ? 8'h00 : r[23:16] & r[31:24];
      cycle();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule